// File: doc/BRIEF.md
# Serial DAC Input Interface Controller

This block is the digital front end of a serially loaded digital-to-analog converter. A host writes 16-bit frames over a three-wire link made of a serial clock, an active-low frame strobe and a data line. The block oversamples all three pins with its own system clock. It shifts each frame in MSB first and decodes the two leading command bits. On a valid load frame, it moves a left-justified data field of `DATA_W` bits into the converter code register.

One command changes which serial-clock edge samples the data line. The new edge applies from the following frame onward. It lasts until the next reset. The frame that carries this command leaves the code register alone and marks the converter as idle until a later load frame arrives. Frames that end early are dropped without side effects.

Top module: `sdac_frontend`

## Requirements
- R1: While reset is asserted and right after it is released, `dac_code` is zero, `sample_rising` is 0 (falling-edge sampling), `dac_active` is 1 and `dac_update` is 0.
- R2: A frame holds 16 bits, sent MSB first. Bits [15:14] are the command. Command 00 loads frame bits [13:14-DATA_W] into `dac_code` when `sync_n` rises after exactly 16 active edges, with a `dac_update` pulse lasting one system clock.
- R3: Frame bits [13-DATA_W:0] do not affect `dac_code`.
- R4: Commands 01 and 10 leave `dac_code`, `sample_rising` and `dac_active` unchanged and raise no `dac_update`.
- R5: Command 11 sets `sample_rising` to 1, which holds until reset. After that, data is taken on rising `sclk` edges and falling edges are ignored. Before it, only falling edges are used.
- R6: A command-11 frame raises no `dac_update` and leaves `dac_code` unchanged. It drives `dac_active` to 0, and `dac_active` stays 0 until the next command-00 frame completes.
- R7: If `sync_n` rises after fewer than 16 active edges, the frame is discarded and no output changes.
- R8: Active edges after the 16th in one frame are ignored; the frame is formed from the first 16 bits.
- R9: `sclk` edges while `sync_n` is high shift nothing and change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| sync_n | input | 1 | Active-low frame strobe (asynchronous) |
| sdin | input | 1 | Serial data, MSB first (asynchronous) |
| dac_code | output | DATA_W | Converter code register |
| dac_update | output | 1 | One-cycle pulse when `dac_code` is loaded |
| sample_rising | output | 1 | 1 when rising `sclk` edges sample data |
| dac_active | output | 1 | 0 after an edge-select frame until the next load |

## Verification
Cycle-level properties cover several behaviours:
- Between load commands, the code register holds and no update pulse appears.
- The edge selection never falls back once set.
- An edge-select frame leaves the converter idle without an update.
- The shift register freezes while the strobe is high and once 16 bits are in.

The scoreboard scenarios cover what only a whole serial transaction can show:
- The extracted field value for several patterns.
- Insensitivity to the trailing bits.
- Dropping of short and overlong bit runs.
- Data actually being taken on the opposite clock edge after the mode switch, with deliberately wrong data placed on the ignored edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int FRAME_BITS = 16;
  localparam int CMD_BITS   = 2;

  typedef enum logic [CMD_BITS-1:0] {
    CMD_LOAD  = 2'b00,
    CMD_RSV_A = 2'b01,
    CMD_RSV_B = 2'b10,
    CMD_EDGE  = 2'b11
  } sdac_cmd_e;

endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];
  logic [W-1:0] hist_q;

  always_comb begin
    stg_d[0] = pin_i;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= RST_VAL;
      end
      hist_q <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= stg_d[i];
      end
      hist_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~hist_q;
  assign fall_o = ~stg_q[STAGES-1] & hist_q;

endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_rising,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               sdin_lvl,
  input  logic               sync_n_lvl,
  input  logic               sync_fall,
  input  logic               sync_rise,
  output logic [FRAME_W-1:0] frame_q,
  output logic               frame_done
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic               frame_full;
  logic               act_edge;
  logic               shift_en;

  always_comb begin
    frame_full = (cnt_q == FULL_CNT);
    act_edge   = sel_rising ? sclk_rise : sclk_fall;
    shift_en   = !sync_n_lvl && !sync_fall && act_edge && !frame_full;
    frame_done = sync_rise && frame_full;

    cnt_d   = cnt_q;
    shift_d = shift_q;
    if (sync_fall || sync_rise) begin
      cnt_d = '0;
    end else if (shift_en) begin
      cnt_d   = cnt_q + 1'b1;
      shift_d = {shift_q[FRAME_W-2:0], sdin_lvl};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
    end
  end

  assign frame_q = shift_q;

  // R8: once a full frame is held, further edges leave it untouched
  a_r8_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_full && !sync_fall && !sync_rise) |=> $stable(shift_q));

  // R9: nothing shifts while the strobe is high
  a_r9_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n_lvl |=> $stable(shift_q));

endmodule

// File: rtl/sdac_cmd_exec.sv
module sdac_cmd_exec
  import sdac_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 12,
  localparam int LOW_W  = FRAME_W - CMD_BITS - DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] frame_q,
  output logic [DATA_W-1:0]  dac_code,
  output logic               dac_update,
  output logic               sel_rising,
  output logic               dac_active
);

  sdac_cmd_e         cmd;
  logic [DATA_W-1:0] field;
  logic [DATA_W-1:0] code_q, code_d;
  logic              upd_q, upd_d;
  logic              rise_q, rise_d;
  logic              act_q, act_d;

  assign cmd   = sdac_cmd_e'(frame_q[FRAME_W-1 -: CMD_BITS]);
  assign field = frame_q[FRAME_W-CMD_BITS-1 -: DATA_W];

  generate
    if (LOW_W > 0) begin : g_low_unused
      logic unused_low_bits;
      assign unused_low_bits = ^frame_q[LOW_W-1:0];
    end
  endgenerate

  always_comb begin
    code_d = code_q;
    upd_d  = 1'b0;
    rise_d = rise_q;
    act_d  = act_q;
    if (frame_done) begin
      case (cmd)
        CMD_LOAD: begin
          code_d = field;
          upd_d  = 1'b1;
          act_d  = 1'b1;
        end
        CMD_EDGE: begin
          rise_d = 1'b1;
          act_d  = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
      rise_q <= 1'b0;
      act_q  <= 1'b1;
    end else begin
      code_q <= code_d;
      upd_q  <= upd_d;
      rise_q <= rise_d;
      act_q  <= act_d;
    end
  end

  assign dac_code   = code_q;
  assign dac_update = upd_q;
  assign sel_rising = rise_q;
  assign dac_active = act_q;

  // R4: without a completed load command the code holds and no strobe appears
  a_r4_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && cmd == CMD_LOAD) |=> ($stable(code_q) && !upd_q));

  // R5: rising-edge selection is sticky until reset
  a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> rise_q);

  // R6: an edge-select frame idles the converter without an update
  a_r6_edge_cmd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && cmd == CMD_EDGE) |=> (!act_q && !upd_q && rise_q));

  // R2: the update strobe lasts one cycle
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);

endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdin,
  output logic [DATA_W-1:0] dac_code,
  output logic              dac_update,
  output logic              sample_rising,
  output logic              dac_active
);

  localparam int PIN_W = 3;
  localparam int P_SYNC = 2;
  localparam int P_SCLK = 1;
  localparam int P_SDIN = 0;

  logic [1:0]            rst_pipe_q;
  logic                  rst_int_n;
  logic [PIN_W-1:0]      pin_lvl, pin_rise, pin_fall;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  frame_done;
  logic                  sel_rising;
  logic                  unused_sdin_edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  sdac_pin_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_pins (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  ({sync_n, sclk, sdin}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign unused_sdin_edges = pin_rise[P_SDIN] ^ pin_fall[P_SDIN];

  sdac_frame_rx #(
    .FRAME_W (FRAME_BITS)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sel_rising (sel_rising),
    .sclk_rise  (pin_rise[P_SCLK]),
    .sclk_fall  (pin_fall[P_SCLK]),
    .sdin_lvl   (pin_lvl[P_SDIN]),
    .sync_n_lvl (pin_lvl[P_SYNC]),
    .sync_fall  (pin_fall[P_SYNC]),
    .sync_rise  (pin_rise[P_SYNC]),
    .frame_q    (frame_q),
    .frame_done (frame_done)
  );

  sdac_cmd_exec #(
    .FRAME_W (FRAME_BITS),
    .DATA_W  (DATA_W)
  ) u_exec (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_done (frame_done),
    .frame_q    (frame_q),
    .dac_code   (dac_code),
    .dac_update (dac_update),
    .sel_rising (sel_rising),
    .dac_active (dac_active)
  );

  assign sample_rising = sel_rising;

  // R1: held reset keeps the code at zero scale
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_int_n |=> (dac_code == '0 && !dac_update));

endmodule

// File: tb/sdac_frontend_bench.sv
module sdac_frontend_bench;

  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sclk;
  logic          sync_n;
  logic          sdin;
  logic [DW-1:0] dac_code;
  logic          dac_update;
  logic          sample_rising;
  logic          dac_active;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] model_code;
  logic          model_rise;
  logic          model_act;
  logic          upd_prev;
  logic          mon_en;

  always #2.5 clk = ~clk;

  sdac_frontend #(.DATA_W(DW)) u_sdac_frontend (
    .clk           (clk),
    .rst_n         (rst_n),
    .sclk          (sclk),
    .sync_n        (sync_n),
    .sdin          (sdin),
    .dac_code      (dac_code),
    .dac_update    (dac_update),
    .sample_rising (sample_rising),
    .dac_active    (dac_active)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every update strobe pops one expected code
  always @(negedge clk) begin
    if (mon_en) begin
      if (dac_update) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected update: actual %0h expected none", dac_code);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          if (dac_code !== e) begin
            errors++;
            $display("FAIL R2 loaded code: actual %0h expected %0h", dac_code, e);
          end
        end
        if (upd_prev) begin
          errors++;
          $display("FAIL R2 strobe width: actual 2+ cycles expected 1");
        end
      end
      upd_prev = dac_update;
    end
  end

  // one serial bit; the ignored edge carries the inverted bit
  task automatic drive_bit(input logic b);
    if (!model_rise) begin
      sdin = b;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
      sdin = ~b;
      sclk = 1'b1;
      wait_clk(4);
    end else begin
      sdin = ~b;
      sclk = 1'b0;
      wait_clk(4);
      sdin = b;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input int nbits);
    sync_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      drive_bit((i < 16) ? w[15-i] : i[0]);
    end
    wait_clk(4);
    if (nbits >= 16) begin
      if (w[15:14] == 2'b00) begin
        model_code = w[13 -: DW];
        model_act  = 1'b1;
        exp_q.push_back(w[13 -: DW]);
      end else if (w[15:14] == 2'b11) begin
        model_rise = 1'b1;
        model_act  = 1'b0;
      end
    end
    sync_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic check_state(input string req);
    @(negedge clk);
    check(dac_code === model_code, req, "dac_code", int'(dac_code), int'(model_code));
    check(sample_rising === model_rise, req, "sample_rising", int'(sample_rising), int'(model_rise));
    check(dac_active === model_act, req, "dac_active", int'(dac_active), int'(model_act));
    check(exp_q.size() == 0, req, "pending updates", exp_q.size(), 0);
    wait_clk(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mon_en = 1'b0; upd_prev = 1'b0;
    rst_n = 1'b0; sclk = 1'b1; sync_n = 1'b1; sdin = 1'b0;
    model_code = '0; model_rise = 1'b0; model_act = 1'b1;
    wait_clk(5);
    @(negedge clk);
    check(dac_code === '0, "R1", "code in reset", int'(dac_code), 0);
    check(dac_update === 1'b0, "R1", "update in reset", int'(dac_update), 0);
    wait_clk(1);
    rst_n = 1'b1;
    wait_clk(4);
    mon_en = 1'b1;
    check_state("R1");

    // R2: several load patterns, falling-edge mode
    send_frame(16'h3FFC, 16); check_state("R2");
    send_frame(16'h0000, 16); check_state("R2");
    send_frame(16'h2AA8, 16); check_state("R2");
    send_frame(16'h1234, 16); check_state("R2");
    // R3: only trailing bits differ
    send_frame(16'h0ABF, 16); check_state("R3");
    send_frame(16'h0ABC, 16); check_state("R3");
    // R4: reserved commands
    send_frame(16'h7FFF, 16); check_state("R4");
    send_frame(16'h8001, 16); check_state("R4");
    // R7: short frames
    send_frame(16'h0FF0, 10); check_state("R7");
    send_frame(16'hC000, 15); check_state("R7");
    // R8: overlong frame keeps first 16 bits
    send_frame(16'h1F0C, 21); check_state("R8");
    // R9: clock activity with the strobe high
    for (int k = 0; k < 16; k++) begin
      sdin = k[1];
      sclk = 1'b0; wait_clk(4);
      sclk = 1'b1; wait_clk(4);
    end
    check_state("R9");
    // R5/R6: edge-select command
    send_frame(16'hC0F0, 16); check_state("R6");
    send_frame(16'h5555, 16); check_state("R6");
    send_frame(16'h2468, 16); check_state("R5");
    send_frame(16'h0F0C, 16); check_state("R5");
    send_frame(16'hFFFF, 16); check_state("R5");
    send_frame(16'h3330, 16); check_state("R6");
    send_frame(16'h0001, 12); check_state("R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule